// File: doc/BRIEF.md
# Up/Down Counter/Timer Channel

This block is one 24-bit counter/timer channel for a data-acquisition or control chip. On each qualified event of its chosen source, it steps a count up or down. The source can be a fast timebase tick, a slow timebase tick, or an external pin with a selectable active edge. A gate pin can hold counting off while it is inactive. It can also act as a start trigger that enables counting from its first active edge. The direction comes from a software bit or from a dedicated up/down pin.

When the count reaches its terminal value, the channel reloads from a load register and raises a one-clock terminal-count flag. It also updates an output line. That line either pulses for one clock or changes level on each terminal count, and software chooses its polarity. Software sets the channel up through a small write-only register port: a control word, a load value, and a command that copies the load value into the count. All pin inputs pass through two-flop synchronisers before any edge is detected.

Top module: `gp_updown_ctr`

## Requirements
- R1: After reset the count is 0, the terminal-count flag is 0, the output line is 0, and every control field is cleared, so the channel is disarmed.
- R2: Control bits [2:1] select the count source: 0 selects the fast tick, 1 selects the slow tick, and 2 or 3 selects the external source pin. A source that is not selected never moves the count.
- R3: The external source counts on its rising edge when control bit 3 is 0 and on its falling edge when it is 1. A new pin level is first sampled at some clock edge. The count changes at the second clock edge after that one, and the opposite edge has no effect.
- R4: While control bit 0 (arm) is 0, source events do not change the count.
- R5: When control bit 7 is 0, control bit 8 sets the direction (1 up, 0 down). When bit 7 is 1, the synchronised up/down pin sets it (1 up, 0 down). Each step moves the count by exactly one.
- R6: A step from 0 while counting down, or from 2^24-1 while counting up, loads the count from the load register (address 1) instead. It also drives the terminal-count flag high for that one clock.
- R7: With gating enabled (control bit 4) in level mode (control bit 5 = 0), steps occur only while the synchronised gate is active. Control bit 6 = 0 makes high the active level, and 1 makes low the active level.
- R8: In edge mode (control bits 4 and 5 both 1), counting is blocked until the first active gate edge after arming: rising when bit 6 is 0, falling when bit 6 is 1. After that edge, counting continues whatever the gate level, until the channel is disarmed.
- R9: In pulse mode (control bit 9 = 0), the output line is active for exactly the clock in which the terminal-count flag is high.
- R10: In toggle mode (control bit 9 = 1), the output line inverts its level on each terminal count and holds it otherwise.
- R11: Control bit 10 = 1 inverts the output line in both modes, so in pulse mode the idle level is 1.
- R12: A write to address 2 copies the load register into the count at that clock edge. It takes precedence over a step in the same clock and raises no terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 load value, 2 load command |
| cfg_wdata | input | 24 | Register write data |
| tick_fast_i | input | 1 | Fast timebase tick, one clock wide |
| tick_slow_i | input | 1 | Slow timebase tick, one clock wide |
| src_ext_i | input | 1 | External count source pin, asynchronous |
| gate_i | input | 1 | Gate pin, asynchronous |
| updn_i | input | 1 | Hardware direction pin, asynchronous (1 = up) |
| cnt_o | output | 24 | Current count value |
| tc_o | output | 1 | Terminal-count flag, one clock per wrap |
| out_o | output | 1 | Counter output line |

## Verification
Some behaviours are checked by assertions on every cycle:
- Outside a wrap or a load command, the count moves by at most one.
- Each terminal count leaves the count equal to the load value in force at that edge.
- In pulse mode, the output follows the flag under the chosen polarity.
- In toggle mode, the output changes level exactly on terminal-count cycles.
- A disarmed channel holds its count.

Other behaviours depend on sequences of pin activity, so only the bench scenarios can show them:
- Source selection.
- The two-clock synchroniser delay on the external edges.
- The choice of active edge.
- Gate level qualification and the gate start trigger.
- Hardware direction control.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [1:0] {
    SRC_FAST    = 2'd0,
    SRC_SLOW    = 2'd1,
    SRC_EXT     = 2'd2,
    SRC_EXT_ALT = 2'd3
  } src_sel_e;

  // Packed MSB first; arm sits at bit 0, output polarity at bit 10.
  typedef struct packed {
    logic     out_pol;
    logic     out_tog;
    logic     dir_up_sw;
    logic     dir_hw;
    logic     gate_pol;
    logic     gate_edge;
    logic     gate_en;
    logic     src_fall;
    src_sel_e src_sel;
    logic     arm;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LOAD = 2'd1;
  localparam logic [1:0] ADDR_GO   = 2'd2;

endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = async_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpc_edge.sv
module gpc_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/gpc_cfg.sv
module gpc_cfg
  import gpc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] load_o,
  output logic             go_o
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic             ctrl_en, load_en;

  assign ctrl_en = we_i && (addr_i == ADDR_CTRL);
  assign load_en = we_i && (addr_i == ADDR_LOAD);
  assign go_o    = we_i && (addr_i == ADDR_GO);

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    if (ctrl_en) ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
    if (load_en) load_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;

endmodule

// File: rtl/gpc_core.sv
module gpc_core
  import gpc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             go_i,
  input  logic             src_evt_i,
  input  logic             gate_lvl_i,
  input  logic             gate_rise_i,
  input  logic             gate_fall_i,
  input  logic             updn_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o,
  output logic             out_o
);

  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tc_q, tc_d, tog_q, tog_d, out_q, out_d;
  logic             started_q, started_d;
  logic             gate_hit, gate_active, gate_ok, step, up, at_term;

  always_comb begin
    gate_hit    = ctrl_i.gate_pol ? gate_fall_i : gate_rise_i;
    gate_active = gate_lvl_i ^ ctrl_i.gate_pol;
    started_d   = ctrl_i.arm &&
                  (started_q || (ctrl_i.gate_en && ctrl_i.gate_edge && gate_hit));
    if (!ctrl_i.gate_en)       gate_ok = 1'b1;
    else if (ctrl_i.gate_edge) gate_ok = started_q;
    else                       gate_ok = gate_active;

    step    = ctrl_i.arm && gate_ok && src_evt_i && !go_i;
    up      = ctrl_i.dir_hw ? updn_i : ctrl_i.dir_up_sw;
    at_term = up ? (cnt_q == TOP_VAL) : (cnt_q == '0);

    cnt_d = cnt_q;
    tc_d  = 1'b0;
    if (go_i) begin
      cnt_d = load_i;
    end else if (step) begin
      if (at_term) begin
        cnt_d = load_i;
        tc_d  = 1'b1;
      end else if (up) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    tog_d = tog_q ^ tc_d;
    out_d = ctrl_i.out_pol ^ (ctrl_i.out_tog ? tog_d : tc_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tc_q      <= 1'b0;
      tog_q     <= 1'b0;
      out_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      tc_q      <= tc_d;
      tog_q     <= tog_d;
      out_q     <= out_d;
      started_q <= started_d;
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;
  assign out_o = out_q;

endmodule

// File: rtl/gp_updown_ctr.sv
module gp_updown_ctr
  import gpc_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             tick_fast_i,
  input  logic             tick_slow_i,
  input  logic             src_ext_i,
  input  logic             gate_i,
  input  logic             updn_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o,
  output logic             out_o
);

  localparam int PIN_W = 3;   // {updn, gate, src}
  localparam int EDG_W = 2;   // {gate, src}

  logic [1:0]       rst_q;
  logic             core_rst_n;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic             ld_go;
  logic [PIN_W-1:0] pin_sync;
  logic [EDG_W-1:0] pin_rise, pin_fall;
  logic             ext_evt, src_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign core_rst_n = rst_q[1];

  gpc_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(core_rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .ctrl_o(ctrl_q), .load_o(load_q), .go_o(ld_go)
  );

  gpc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(core_rst_n),
    .async_i({updn_i, gate_i, src_ext_i}), .sync_o(pin_sync)
  );

  gpc_edge #(.WIDTH(EDG_W)) edge_i (
    .clk(clk), .rst_n(core_rst_n), .lvl_i(pin_sync[EDG_W-1:0]),
    .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign ext_evt = ctrl_q.src_fall ? pin_fall[0] : pin_rise[0];

  always_comb begin
    unique case (ctrl_q.src_sel)
      SRC_FAST: src_evt = tick_fast_i;
      SRC_SLOW: src_evt = tick_slow_i;
      default:  src_evt = ext_evt;
    endcase
  end

  gpc_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(core_rst_n), .ctrl_i(ctrl_q), .load_i(load_q),
    .go_i(ld_go), .src_evt_i(src_evt), .gate_lvl_i(pin_sync[1]),
    .gate_rise_i(pin_rise[1]), .gate_fall_i(pin_fall[1]),
    .updn_i(pin_sync[2]), .cnt_o(cnt_o), .tc_o(tc_o), .out_o(out_o)
  );

endmodule

// File: rtl/gp_updown_ctr_chk.sv
module gp_updown_ctr_chk
  import gpc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] load_val,
  input logic             ld_go,
  input logic [CNT_W-1:0] cnt,
  input logic             tc,
  input logic             out
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt == '0) && !tc && !out); // R1

  AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.arm && !ld_go) |=> $stable(cnt)); // R4

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc && !$past(ld_go)) |->
      ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R5

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (cnt == $past(load_val))); // R6

  AST_PULSE_FOLLOWS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl.out_tog) |-> (out == ($past(ctrl.out_pol) ^ tc))); // R9

  AST_TOGGLE_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.out_tog) && $past(ctrl.out_tog, 2) &&
     ($past(ctrl.out_pol) == $past(ctrl.out_pol, 2)))
      |-> ((out != $past(out)) == tc)); // R10

endmodule

bind gp_updown_ctr gp_updown_ctr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .load_val(load_q), .ld_go(ld_go),
  .cnt(cnt_o), .tc(tc_o), .out(out_o)
);

// File: tb/gp_updown_ctr_tb_top.sv
`timescale 1ns/1ps
module gp_updown_ctr_tb_top;

  localparam int W = 24;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = 2'd0;
  logic [W-1:0] cfg_wdata = '0;
  logic         tick_f = 1'b0, tick_s = 1'b0;
  logic         src_pin = 1'b0, gate_pin = 1'b0, updn_pin = 1'b0;
  logic [W-1:0] cnt;
  logic         tc, out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  gp_updown_ctr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick_fast_i(tick_f), .tick_slow_i(tick_s),
    .src_ext_i(src_pin), .gate_i(gate_pin), .updn_i(updn_pin),
    .cnt_o(cnt), .tc_o(tc), .out_o(out)
  );

  // ---------------- behavioural reference model ----------------
  int       m_cnt, m_load, m_tc, m_out, m_tog, m_started;
  bit [10:0] m_ctrl;
  bit [2:0] hist[$];   // pin samples, newest first: {updn, gate, src}

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_tc = 0; m_out = 0; m_tog = 0; m_started = 0;
      m_ctrl = '0;
      hist = '{3'b0, 3'b0, 3'b0};
    end else begin
      bit [2:0] cur, old;
      bit arm, sfall, gen, gedge, gpol, dhw, dup, tmode, pol;
      int sel;
      bit src_ev, grise, gfall, ghit, gok, up, go, step;
      cur = hist[1]; old = hist[2];
      arm = m_ctrl[0]; sel = m_ctrl[2:1]; sfall = m_ctrl[3]; gen = m_ctrl[4];
      gedge = m_ctrl[5]; gpol = m_ctrl[6]; dhw = m_ctrl[7]; dup = m_ctrl[8];
      tmode = m_ctrl[9]; pol = m_ctrl[10];
      if (sel == 0)      src_ev = tick_f;
      else if (sel == 1) src_ev = tick_s;
      else               src_ev = sfall ? (old[0] && !cur[0]) : (cur[0] && !old[0]);
      grise = cur[1] && !old[1];
      gfall = !cur[1] && old[1];
      ghit  = gpol ? gfall : grise;
      if (!gen)       gok = 1;
      else if (gedge) gok = (m_started != 0);
      else            gok = cur[1] ^ gpol;
      up   = dhw ? cur[2] : dup;
      go   = cfg_we && (cfg_addr == 2'd2);
      step = arm && gok && src_ev && !go;
      m_tc = 0;
      if (go) m_cnt = m_load;
      else if (step) begin
        if (up && m_cnt == int'(MAXV))  begin m_cnt = m_load; m_tc = 1; end
        else if (!up && m_cnt == 0)     begin m_cnt = m_load; m_tc = 1; end
        else if (up)                    m_cnt = m_cnt + 1;
        else                            m_cnt = m_cnt - 1;
      end
      if (m_tc != 0) m_tog = 1 - m_tog;
      m_out = int'(pol) ^ (tmode ? m_tog : m_tc);
      m_started = (arm && (m_started != 0 || (gen && gedge && ghit))) ? 1 : 0;
      if (cfg_we && cfg_addr == 2'd0) m_ctrl = cfg_wdata[10:0];
      if (cfg_we && cfg_addr == 2'd1) m_load = int'(cfg_wdata);
      hist.push_front({updn_pin, gate_pin, src_pin});
      void'(hist.pop_back());
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (cnt != m_cnt[W-1:0] || tc != m_tc[0] || out != m_out[0]) begin
        n_fail++;
        $display("FAIL model compare R5/R6/R10: actual cnt=%0h tc=%0b out=%0b expected cnt=%0h tc=%0b out=%0b",
                 cnt, tc, out, m_cnt[W-1:0], m_tc[0], m_out[0]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic ticks_fast(input int n);
    tick_f = 1'b1;
    repeat (n) @(negedge clk);
    tick_f = 1'b0;
  endtask

  task automatic ticks_slow(input int n);
    tick_s = 1'b1;
    repeat (n) @(negedge clk);
    tick_s = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] mk(bit arm, bit [1:0] sel, bit sfall, bit gen,
                                      bit gedge, bit gpol, bit dhw, bit dup,
                                      bit tmode, bit pol);
    return W'({pol, tmode, dup, dhw, gpol, gedge, gen, sfall, sel, arm});
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(5);
    chk("R1 count", int'(cnt), 0);
    chk("R1 tc", int'(tc), 0);
    chk("R1 out", int'(out), 0);

    wr(2'd1, 24'd5); wr(2'd2, '0);
    chk("R12 load command", int'(cnt), 5);

    wr(2'd0, mk(1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0));
    ticks_fast(3);
    chk("R2 fast source down", int'(cnt), 2);

    wr(2'd0, mk(1, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0));
    ticks_fast(2);
    chk("R2 unselected fast tick", int'(cnt), 2);
    ticks_slow(2);
    chk("R2 slow source", int'(cnt), 0);

    wr(2'd0, mk(0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0));
    ticks_slow(4);
    chk("R4 disarmed", int'(cnt), 0);
    chk("R4 no tc when disarmed", int'(tc), 0);

    wr(2'd1, 24'd1); wr(2'd2, '0);
    wr(2'd0, mk(1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0));
    ticks_fast(1);
    chk("R5 down step", int'(cnt), 0);
    ticks_fast(1);
    chk("R6 down reload", int'(cnt), 1);
    chk("R6 tc at zero", int'(tc), 1);
    chk("R9 pulse active", int'(out), 1);
    idle(1);
    chk("R9 pulse one clock", int'(out), 0);
    chk("R6 tc one clock", int'(tc), 0);

    wr(2'd1, MAXV); wr(2'd2, '0);
    wr(2'd0, mk(1, 2'd0, 0, 0, 0, 0, 0, 1, 0, 0));
    ticks_fast(1);
    chk("R6 tc at top", int'(tc), 1);
    chk("R6 up reload", int'(cnt), int'(MAXV));
    wr(2'd1, 24'h10); wr(2'd2, '0);
    ticks_fast(2);
    chk("R5 up step", int'(cnt), 'h12);

    wr(2'd0, mk(1, 2'd0, 0, 0, 0, 0, 1, 1, 0, 0));
    ticks_fast(2);
    chk("R5 hw pin down overrides sw up", int'(cnt), 'h10);
    updn_pin = 1'b1; idle(3);
    ticks_fast(1);
    chk("R5 hw pin up", int'(cnt), 'h11);

    wr(2'd1, 24'd0); wr(2'd2, '0);
    wr(2'd0, mk(1, 2'd0, 0, 0, 0, 0, 0, 0, 1, 0));
    chk("R10 toggle start", int'(out), 0);
    ticks_fast(1);
    chk("R10 toggle first tc", int'(out), 1);
    idle(2);
    chk("R10 toggle holds", int'(out), 1);
    ticks_fast(1);
    chk("R10 toggle second tc", int'(out), 0);

    wr(2'd0, mk(1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1));
    idle(1);
    chk("R11 inverted idle", int'(out), 1);
    ticks_fast(1);
    chk("R11 inverted pulse", int'(out), 0);
    idle(1);
    chk("R11 back to idle", int'(out), 1);

    wr(2'd1, 24'd3); wr(2'd2, '0);
    wr(2'd0, mk(1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0));
    src_pin = 1'b1;
    idle(2);
    chk("R3 not yet through sync", int'(cnt), 3);
    idle(1);
    chk("R3 rising edge counted", int'(cnt), 2);
    src_pin = 1'b0; idle(4);
    chk("R3 falling ignored", int'(cnt), 2);
    wr(2'd0, mk(1, 2'd2, 1, 0, 0, 0, 0, 0, 0, 0));
    src_pin = 1'b1; idle(4);
    chk("R3 rising ignored in falling mode", int'(cnt), 2);
    src_pin = 1'b0; idle(2);
    chk("R3 falling not yet through sync", int'(cnt), 2);
    idle(1);
    chk("R3 falling edge counted", int'(cnt), 1);

    wr(2'd1, 24'd9); wr(2'd2, '0);
    wr(2'd0, mk(1, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0));
    idle(3);
    ticks_fast(3);
    chk("R7 gate low blocks", int'(cnt), 9);
    gate_pin = 1'b1; idle(3);
    ticks_fast(2);
    chk("R7 gate high counts", int'(cnt), 7);
    wr(2'd0, mk(1, 2'd0, 0, 1, 0, 1, 0, 0, 0, 0));
    ticks_fast(2);
    chk("R7 active-low gate blocks when high", int'(cnt), 7);

    wr(2'd0, mk(0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(2'd0, mk(1, 2'd0, 0, 1, 1, 0, 0, 0, 0, 0));
    gate_pin = 1'b0; idle(3);
    ticks_fast(2);
    chk("R8 no start without rising edge", int'(cnt), 7);
    gate_pin = 1'b1; idle(3);
    gate_pin = 1'b0; idle(3);
    ticks_fast(2);
    chk("R8 counts after start edge", int'(cnt), 5);

    wr(2'd0, mk(1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(2'd1, 24'h40);
    tick_f = 1'b1;
    wr(2'd2, '0);
    tick_f = 1'b0;
    chk("R12 load beats step", int'(cnt), 'h40);
    chk("R12 no tc on load", int'(tc), 0);

    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule